// File: doc/BRIEF.md
# Keyword-Gated Watchdog Timer

This block is a memory-mapped watchdog. A 20-bit down-counter decrements on a one-cycle tick strobe that arrives from an external divider. When it runs out, the block latches an interrupt and sends a one-cycle request to the system reset controller. Software controls it through two 32-bit registers. A control register acts only on exact 16-bit keywords. A count register exposes bits [19:4] of the counter.

Keywords stop and resume counting, clear the pending interrupt, open and close a write window for the count register, and force the counter to its full value. The full-value keyword works whether or not the window is open. A read of the control register returns a status word. A read of the count register returns the high part of the live counter.

A restart is forced with a five-step sequence: stop, unlock, write a count of 1, lock, resume. The counter then expires after a short run of ticks.

Top module: `kw_watchdog`

## Requirements
- R1: After reset, counting is stopped, the count window is closed, no interrupt is pending, `sys_rst_req` is low, and the count register reads 0xFFFF.
- R2: While running, each cycle with `tick_en` high lowers the 20-bit counter by one, provided the counter is not zero and no load happens in that cycle.
- R3: Keyword 0x3877 written to the control register (byte offset 0) stops counting and holds the counter value. Keyword 0x4A4B resumes counting from the held value.
- R4: A write to the count register (byte offset 4) takes effect only while the window is open. Keyword 0xAB00 opens the window and 0xAB01 closes it. A write while the window is closed leaves the counter unchanged.
- R5: An accepted count write loads bits [15:0] of the write data, shifted left by 4, into the counter. A count read returns counter[19:4] in bits [15:0], with bits [31:16] at zero.
- R6: Keyword 0xDEAF sets the counter to 0xFFFF0, whether the window is open or closed.
- R7: A control write whose bits [15:0] match no keyword, or a write to any other offset, changes neither the status nor the counter. Bits [31:16] of a control write are ignored.
- R8: A tick while running with the counter at zero expires the counter. On that edge the interrupt flag (`irq`) is set and the counter reloads to 0xFFFF0. `sys_rst_req` is high for exactly the following cycle.
- R9: Keyword 0x7482 clears the pending interrupt. If an expiry falls in the same cycle, the expiry wins and the interrupt stays pending.
- R10: A control read returns running in bit 0, window-open in bit 1 and interrupt-pending in bit 2, with all other bits at zero.
- R11: After the sequence stop, unlock, count 1, lock, resume, the 17th tick causes expiry.
- R12: A count write or a 0xDEAF keyword takes priority over a tick in the same cycle. The loaded value is not decremented in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle count strobe from the divider |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Byte offset: 0 control, 4 count |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Pending expiry interrupt, sticky |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
Two functions can meet in one cycle. The first pair is an expiry and a clear-interrupt keyword. The bench provokes this by running the counter to zero and then issuing 0x7482 in the same cycle as a tick. It expects the interrupt to remain set and the reset request to fire. The second pair is a count load or full-value keyword and a tick. The bench expects the loaded value with no decrement. Random traffic repeats both collisions, and each cycle is judged against a bench-side model built from the requirements.

// File: rtl/kw_watchdog_pkg.sv
package kw_watchdog_pkg;

    localparam int CNT_W_DEF  = 20;
    localparam int SHIFT_DEF  = 4;
    localparam int KEY_W      = 16;
    localparam int DATA_W_DEF = 32;

    localparam logic [KEY_W-1:0] KEY_HALT    = 16'h3877;
    localparam logic [KEY_W-1:0] KEY_GO      = 16'h4A4B;
    localparam logic [KEY_W-1:0] KEY_ACK_IRQ = 16'h7482;
    localparam logic [KEY_W-1:0] KEY_OPEN    = 16'hAB00;
    localparam logic [KEY_W-1:0] KEY_CLOSE   = 16'hAB01;
    localparam logic [KEY_W-1:0] KEY_FULL    = 16'hDEAF;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_HALT,
        CMD_GO,
        CMD_ACK_IRQ,
        CMD_OPEN,
        CMD_CLOSE,
        CMD_FULL
    } kw_cmd_e;

    typedef struct packed {
        logic irq_pend;
        logic unlocked;
        logic running;
    } kw_status_t;

    function automatic kw_cmd_e kw_decode(input logic [KEY_W-1:0] key);
        kw_cmd_e c;
        case (key)
            KEY_HALT:    c = CMD_HALT;
            KEY_GO:      c = CMD_GO;
            KEY_ACK_IRQ: c = CMD_ACK_IRQ;
            KEY_OPEN:    c = CMD_OPEN;
            KEY_CLOSE:   c = CMD_CLOSE;
            KEY_FULL:    c = CMD_FULL;
            default:     c = CMD_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/kw_cmd_decode.sv
module kw_cmd_decode
    import kw_watchdog_pkg::*;
(
    input  logic             wr_ctrl,
    input  logic [KEY_W-1:0] key,
    output kw_cmd_e          cmd
);

    always_comb begin
        cmd = CMD_NONE;
        if (wr_ctrl) begin
            cmd = kw_decode(key);
        end
    end

endmodule

// File: rtl/kw_ctrl_state.sv
module kw_ctrl_state
    import kw_watchdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  kw_cmd_e    cmd,
    input  logic       expire,
    output kw_status_t st
);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            case (cmd)
                CMD_HALT:  st.running  <= 1'b0;
                CMD_GO:    st.running  <= 1'b1;
                CMD_OPEN:  st.unlocked <= 1'b1;
                CMD_CLOSE: st.unlocked <= 1'b0;
                default: ;
            endcase
            // expiry has priority over the acknowledge keyword
            if (expire) begin
                st.irq_pend <= 1'b1;
            end else if (cmd == CMD_ACK_IRQ) begin
                st.irq_pend <= 1'b0;
            end
        end
    end

    p_irq_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (st.irq_pend && cmd != CMD_ACK_IRQ) |=> st.irq_pend);

    p_expire_wins_r9: assert property (@(posedge clk) disable iff (rst)
        expire |=> st.irq_pend);

    p_junk_no_effect_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_NONE && !expire) |=> $stable(st));

    p_halt_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_HALT) |=> !st.running);

endmodule

// File: rtl/kw_down_counter.sv
module kw_down_counter #(
    parameter int CNT_W = 20,
    parameter int SHIFT = 4,
    localparam int REG_W = CNT_W - SHIFT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             running,
    input  logic             load_en,
    input  logic [REG_W-1:0] load_val,
    input  logic             load_full,
    output logic [CNT_W-1:0] cnt,
    output logic             expire,
    output logic             rst_req
);

    localparam logic [CNT_W-1:0] CNT_FULL = {{REG_W{1'b1}}, {SHIFT{1'b0}}};
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic step;

    assign step   = running && tick_en && !load_en && !load_full;
    assign expire = step && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= CNT_FULL;
            rst_req <= 1'b0;
        end else begin
            rst_req <= expire;
            if (load_en) begin
                cnt <= {load_val, {SHIFT{1'b0}}};
            end else if (load_full || expire) begin
                cnt <= CNT_FULL;
            end else if (step) begin
                cnt <= cnt - CNT_ONE;
            end
        end
    end

    p_step_down_r2: assert property (@(posedge clk) disable iff (rst)
        (running && tick_en && !load_en && !load_full && cnt != '0)
        |=> cnt == $past(cnt) - CNT_ONE);

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!running && !load_en && !load_full) |=> $stable(cnt));

    p_load_shift_r5: assert property (@(posedge clk) disable iff (rst)
        load_en |=> cnt == {$past(load_val), {SHIFT{1'b0}}});

    p_full_r6: assert property (@(posedge clk) disable iff (rst)
        (load_full && !load_en) |=> cnt == CNT_FULL);

    p_expire_reload_r8: assert property (@(posedge clk) disable iff (rst)
        expire |=> (cnt == CNT_FULL) && rst_req);

    p_rst_one_cycle_r8: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

endmodule

// File: rtl/kw_watchdog.sv
module kw_watchdog
    import kw_watchdog_pkg::*;
#(
    parameter int              CNT_W    = CNT_W_DEF,
    parameter int              SHIFT    = SHIFT_DEF,
    parameter int              DATA_W   = DATA_W_DEF,
    parameter int              ADDR_W   = 3,
    parameter logic [ADDR_W-1:0] CTRL_OFF = 3'd0,
    parameter logic [ADDR_W-1:0] CNT_OFF  = 3'd4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              sys_rst_req
);

    localparam int REG_W = CNT_W - SHIFT;

    logic             wr_ctrl;
    logic             wr_cnt;
    logic             load_en;
    kw_cmd_e          cmd;
    kw_status_t       st;
    logic [CNT_W-1:0] cnt;
    logic             expire;
    logic             unused_wdata_hi;

    assign wr_ctrl = bus_wr && (bus_addr == CTRL_OFF);
    assign wr_cnt  = bus_wr && (bus_addr == CNT_OFF);
    assign load_en = wr_cnt && st.unlocked;
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:KEY_W];

    kw_cmd_decode u_dec (
        .wr_ctrl (wr_ctrl),
        .key     (bus_wdata[KEY_W-1:0]),
        .cmd     (cmd)
    );

    kw_ctrl_state u_state (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .expire (expire),
        .st     (st)
    );

    kw_down_counter #(
        .CNT_W (CNT_W),
        .SHIFT (SHIFT)
    ) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .running   (st.running),
        .load_en   (load_en),
        .load_val  (bus_wdata[REG_W-1:0]),
        .load_full (cmd == CMD_FULL),
        .cnt       (cnt),
        .expire    (expire),
        .rst_req   (sys_rst_req)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_OFF) begin
            bus_rdata[$bits(kw_status_t)-1:0] = st;
        end else if (bus_addr == CNT_OFF) begin
            bus_rdata[REG_W-1:0] = cnt[CNT_W-1:SHIFT];
        end
    end

    assign irq = st.irq_pend;

    p_locked_drop_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_cnt && !st.unlocked && !st.running) |=> $stable(cnt));

    p_irq_before_req_r8: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req |-> irq);

endmodule

// File: tb/kw_watchdog_bench.sv
module kw_watchdog_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        tick_en;
    logic        bus_wr;
    logic [2:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        sys_rst_req;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic        m_run, m_unl, m_irq, m_rst;
    logic [19:0] m_cnt;

    localparam logic [19:0] FULL = 20'hFFFF0;

    always #4 clk = ~clk;

    kw_watchdog u_kw_watchdog (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sys_rst_req(sys_rst_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // model derived from the requirements
    task automatic m_update(input logic wr, input logic [2:0] a, input logic [31:0] d, input logic tk);
        logic ld, full, exp_now;
        logic [15:0] k;
        k       = d[15:0];
        ld      = wr && a == 3'd4 && m_unl;
        full    = wr && a == 3'd0 && k == 16'hDEAF;
        exp_now = m_run && tk && !ld && !full && m_cnt == 20'd0;
        m_rst   = exp_now;
        if (ld)                      m_cnt = {d[15:0], 4'h0};
        else if (full || exp_now)    m_cnt = FULL;
        else if (m_run && tk)        m_cnt = m_cnt - 20'd1;
        if (wr && a == 3'd0) begin
            if (k == 16'h3877) m_run = 1'b0;
            if (k == 16'h4A4B) m_run = 1'b1;
            if (k == 16'hAB00) m_unl = 1'b1;
            if (k == 16'hAB01) m_unl = 1'b0;
        end
        if (exp_now) m_irq = 1'b1;
        else if (wr && a == 3'd0 && k == 16'h7482) m_irq = 1'b0;
    endtask

    task automatic cyc(input logic wr, input logic [2:0] a, input logic [31:0] d, input logic tk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; tick_en = tk;
        @(posedge clk);
        m_update(wr, a, d, tk);
        @(negedge clk);
        bus_wr = 1'b0; tick_en = 1'b0;
    endtask

    task automatic check_all(input string tag);
        bus_addr = 3'd0; #1;
        chk({tag, " R10 status"}, bus_rdata, {29'd0, m_irq, m_unl, m_run});
        bus_addr = 3'd4; #1;
        chk({tag, " R5 count"}, bus_rdata, {16'd0, m_cnt[19:4]});
        chk({tag, " irq"}, {31'd0, irq}, {31'd0, m_irq});
        chk({tag, " R8 rst_req"}, {31'd0, sys_rst_req}, {31'd0, m_rst});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog timeout act=%0d exp=%0d", n_chk, 0);
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int tk_n;
        int unsigned seed_v;
        seed_v = $urandom(32'h5EED_0042);
        rst = 1'b1; tick_en = 1'b0; bus_wr = 1'b0; bus_addr = 3'd0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_run = 0; m_unl = 0; m_irq = 0; m_rst = 0; m_cnt = FULL;
        check_all("R1 reset");
        chk("R1 count reads FFFF", bus_rdata, 32'h0000FFFF);

        // R4: locked write dropped
        cyc(1, 3'd4, 32'h1234, 0); check_all("R4 locked");
        chk("R4 locked count", bus_rdata, 32'h0000FFFF);
        // R7: junk keywords and other offsets
        cyc(1, 3'd0, 32'h0000_1111, 0); check_all("R7 junk");
        cyc(1, 3'd0, 32'hFFFF_3876, 0); check_all("R7 near key");
        cyc(1, 3'd2, 32'h0000_AB00, 0); check_all("R7 bad offset");
        // R5: unlock and load
        cyc(1, 3'd0, 32'h0000_AB00, 0); check_all("R4 open");
        cyc(1, 3'd4, 32'hABCD_0003, 0); check_all("R5 load");
        chk("R5 load value", bus_rdata, 32'h0000_0003);
        cyc(1, 3'd0, 32'h5555_AB01, 0); check_all("R7 upper ignored close");
        cyc(1, 3'd4, 32'h0000_0005, 0); check_all("R4 closed drop");
        // R2 counting
        cyc(1, 3'd0, 32'h4A4B, 0); check_all("R3 resume");
        for (int i = 0; i < 20; i++) begin cyc(0, 3'd0, 0, 1); check_all("R2 tick"); end
        // R3 stop holds
        cyc(1, 3'd0, 32'h3877, 1); check_all("R3 stop");
        for (int i = 0; i < 5; i++) begin cyc(0, 3'd0, 0, 1); check_all("R3 hold"); end
        cyc(1, 3'd0, 32'h4A4B, 0); cyc(0, 3'd0, 0, 1); check_all("R3 resume from held");
        // R6 full while locked
        cyc(1, 3'd0, 32'hDEAF, 1); check_all("R6 full locked");
        chk("R6 full value", bus_rdata, 32'h0000FFFF);
        // R11 restart sequence
        cyc(1, 3'd0, 32'h3877, 0);
        cyc(1, 3'd0, 32'hAB00, 0);
        cyc(1, 3'd4, 32'h0001, 0);
        cyc(1, 3'd0, 32'hAB01, 0);
        cyc(1, 3'd0, 32'h4A4B, 0);
        check_all("R11 armed");
        tk_n = 0;
        while (!sys_rst_req && tk_n < 40) begin
            cyc(0, 3'd0, 0, 1); tk_n++; check_all("R8 run down");
        end
        chk("R11 ticks to expiry", tk_n, 17);
        chk("R8 irq set", {31'd0, irq}, 32'd1);
        cyc(0, 3'd0, 0, 0); check_all("R8 pulse ends");
        chk("R8 single pulse", {31'd0, sys_rst_req}, 32'd0);
        // R9 collision: expiry and ack in the same cycle
        cyc(1, 3'd0, 32'h7482, 0); check_all("R9 ack");
        cyc(1, 3'd0, 32'hAB00, 0);
        cyc(1, 3'd4, 32'h0000, 0);
        cyc(1, 3'd0, 32'h7482, 1); check_all("R9 expire wins");
        chk("R9 irq kept", {31'd0, irq}, 32'd1);
        cyc(1, 3'd0, 32'h7482, 0); check_all("R9 cleared");
        // R12 load vs tick
        cyc(1, 3'd4, 32'h0010, 1); check_all("R12 load beats tick");
        chk("R12 value", bus_rdata, 32'h0000_0010);
        cyc(1, 3'd0, 32'hDEAF, 1); check_all("R12 full beats tick");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            int unsigned r;
            logic [31:0] d;
            r = $urandom % 10;
            if (r < 4) begin
                case ($urandom % 8)
                    0: d = 32'h3877; 1: d = 32'h4A4B; 2: d = 32'h7482;
                    3: d = 32'hAB00; 4: d = 32'hAB01; 5: d = (($urandom % 16) == 0) ? 32'hDEAF : 32'h4A4B;
                    default: d = $urandom;
                endcase
                cyc(1, 3'd0, d, 1'($urandom % 2));
            end else if (r < 6) begin
                d = (($urandom % 4) == 0) ? ($urandom & 32'hFFFF) : ($urandom % 3);
                cyc(1, 3'd4, d, 1'($urandom % 2));
            end else begin
                cyc(0, 3'd0, 0, 1'($urandom % 2));
            end
            check_all("R8 random");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule